// File: doc/BRIEF.md
# DMA Bus Tenure Limiter

This block decides when a bus-mastering DMA engine should give the system bus back. A mastership period begins when the grant input rises. From that point, the block runs two limits in parallel. One counts data transfers against a programmable burst limit. The other counts elapsed time in 100 ns ticks against a programmable activity limit. As soon as the first enabled limit is reached, the block raises a release request. The request stays high until the grant is withdrawn. Withdrawing the grant also clears both counters, ready for the next period.

The 100 ns tick comes from a prescaler sized by the `CLK_MHZ` parameter, so each tick is `CLK_MHZ/10` clocks long. Descriptor transfers never count toward the burst limit. A zero in either limit register has its own meaning. In test mode, a write to the burst register decrements it instead of loading it.

Top module: `bus_tenure_limiter`

## Requirements
- R1: After reset, release_req is 0, the burst register holds 16 and the time register holds 0. A period run with no register writes, with the timer off, releases after the 16th data transfer.
- R2: With timer_en=0 and burst_dis=0, release_req rises on the clock edge that samples the Nth data transfer of the period, where N is the burst register value (1..255).
- R3: A burst register value of 0 behaves as a limit of one data transfer.
- R4: A transfer strobe sampled with desc_xfer=1 does not count toward any limit.
- R5: With burst_dis=1, the transfer count never causes a release.
- R6: With timer_en=1 and a time register value T>0, release_req rises on the T*(CLK_MHZ/10)-th clock edge that samples grant high, counted from the start of the period.
- R7: With both limits enabled, the release happens at whichever limit is reached first.
- R8: With timer_en=1 and a time register value of 0, release_req rises on the edge that samples the first data transfer, whatever burst_dis is set to.
- R9: A burst register write made with stop=1 and test_en=1 decrements the register by one (modulo 256) and ignores the write data.
- R10: A burst register write with stop=0 has no effect.
- R11: release_req stays high while grant stays high. It falls on the first edge that samples grant low. Each new period counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Bus grant; high for the whole mastership period |
| xfer | input | 1 | One-cycle strobe for each completed bus transfer |
| desc_xfer | input | 1 | Marks the current transfer as a descriptor transfer |
| timer_en | input | 1 | Turns on the time limit |
| burst_dis | input | 1 | Turns off the transfer count limit |
| stop | input | 1 | High while the engine is stopped; allows burst register writes |
| test_en | input | 1 | Test mode: burst writes decrement |
| burst_we | input | 1 | Burst register write strobe |
| burst_wdata | input | 8 | Burst register write data |
| timer_we | input | 1 | Time register write strobe |
| timer_wdata | input | 16 | Time register write data, in 100 ns units |
| release_req | output | 1 | Registered request to release the bus |

## Verification
Every internal fault in this block appears at one place: the edge on which release_req rises. A transfer counter that is off by one, a prescaler with the wrong modulus, or a burst register corrupted by a decrement or an ignored write moves that edge by a predictable number of clocks. The error therefore shows within the same mastership period. The bench measures this rise edge exactly, in clocks, for each configuration.

A counter that fails to clear when the grant falls shows in the next period as an early release. A counter that never saturates would only show in very long periods.

// File: rtl/blt_pkg.sv
package blt_pkg;
  localparam int BURST_W   = 8;
  localparam int TIMER_W   = 16;
  localparam int XCNT_W    = BURST_W + 1;
  localparam logic [BURST_W-1:0] BURST_RESET = 8'd16;

  // A zero burst value stands for a single transfer.
  function automatic logic [XCNT_W-1:0] eff_burst(input logic [BURST_W-1:0] v);
    return (v == '0) ? XCNT_W'(1) : {1'b0, v};
  endfunction
endpackage

// File: rtl/blt_cfg_regs.sv
module blt_cfg_regs
  import blt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               stop,
  input  logic               test_en,
  input  logic               burst_we,
  input  logic [BURST_W-1:0] burst_wdata,
  input  logic               timer_we,
  input  logic [TIMER_W-1:0] timer_wdata,
  output logic [BURST_W-1:0] burst_q,
  output logic [TIMER_W-1:0] timer_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      burst_q <= BURST_RESET;
    end else if (burst_we && stop) begin
      if (test_en) burst_q <= burst_q - BURST_W'(1);
      else         burst_q <= burst_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           timer_q <= '0;
    else if (timer_we) timer_q <= timer_wdata;
  end
endmodule

// File: rtl/blt_tick_gen.sv
module blt_tick_gen #(
  parameter int DIV = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre;
      always_ff @(posedge clk) begin
        if (rst || !run)     pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                 pre <= pre + PW'(1);
      end
      assign tick = run && (pre == LAST);
    end
  endgenerate
endmodule

// File: rtl/blt_limit_ctrl.sv
module blt_limit_ctrl
  import blt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               grant,
  input  logic               xfer,
  input  logic               desc_xfer,
  input  logic               timer_en,
  input  logic               burst_dis,
  input  logic               tick,
  input  logic [BURST_W-1:0] burst_q,
  input  logic [TIMER_W-1:0] timer_q,
  output logic               release_req
);
  logic [XCNT_W-1:0]  xfer_cnt;
  logic [TIMER_W-1:0] time_cnt;
  logic [XCNT_W:0]    xfer_next;
  logic [TIMER_W:0]   time_next;
  logic data_x, burst_hit, time_hit, zero_hit;

  assign data_x    = grant && xfer && !desc_xfer;
  assign xfer_next = {1'b0, xfer_cnt} + (XCNT_W+1)'(1);
  assign time_next = {1'b0, time_cnt} + (TIMER_W+1)'(1);

  assign burst_hit = !burst_dis && data_x && (xfer_next >= {1'b0, eff_burst(burst_q)});
  assign zero_hit  = timer_en && (timer_q == '0) && data_x;
  assign time_hit  = timer_en && (timer_q != '0) && tick && (time_next >= {1'b0, timer_q});

  always_ff @(posedge clk) begin
    if (rst || !grant) begin
      xfer_cnt <= '0;
      time_cnt <= '0;
    end else begin
      if (data_x && (xfer_cnt != '1)) xfer_cnt <= xfer_cnt + XCNT_W'(1);
      if (tick && (time_cnt != '1))   time_cnt <= time_cnt + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !grant)                        release_req <= 1'b0;
    else if (burst_hit || time_hit || zero_hit) release_req <= 1'b1;
  end
endmodule

// File: rtl/bus_tenure_limiter.sv
module bus_tenure_limiter
  import blt_pkg::*;
#(
  parameter int CLK_MHZ = 200
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         grant,
  input  logic         xfer,
  input  logic         desc_xfer,
  input  logic         timer_en,
  input  logic         burst_dis,
  input  logic         stop,
  input  logic         test_en,
  input  logic         burst_we,
  input  logic [7:0]   burst_wdata,
  input  logic         timer_we,
  input  logic [15:0]  timer_wdata,
  output logic         release_req
);
  localparam int TICK_DIV = (CLK_MHZ / 10 < 1) ? 1 : CLK_MHZ / 10;

  logic [BURST_W-1:0] burst_q;
  logic [TIMER_W-1:0] timer_q;
  logic               tick;

  blt_cfg_regs u_regs (
    .clk(clk), .rst(rst), .stop(stop), .test_en(test_en),
    .burst_we(burst_we), .burst_wdata(burst_wdata),
    .timer_we(timer_we), .timer_wdata(timer_wdata),
    .burst_q(burst_q), .timer_q(timer_q)
  );

  blt_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(grant && timer_en), .tick(tick)
  );

  blt_limit_ctrl u_ctrl (
    .clk(clk), .rst(rst), .grant(grant), .xfer(xfer), .desc_xfer(desc_xfer),
    .timer_en(timer_en), .burst_dis(burst_dis), .tick(tick),
    .burst_q(burst_q), .timer_q(timer_q), .release_req(release_req)
  );
endmodule

// File: rtl/blt_checker.sv
module blt_checker (
  input logic       clk,
  input logic       rst,
  input logic       grant,
  input logic       stop,
  input logic       test_en,
  input logic       burst_we,
  input logic       release_req,
  input logic [7:0] burst_q
);
  a_r1_burst_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> burst_q == 8'd16);

  a_r9_test_decrement: assert property (@(posedge clk) disable iff (rst)
    (burst_we && stop && test_en) |=> burst_q == $past(burst_q) - 8'd1);

  a_r10_locked_write: assert property (@(posedge clk) disable iff (rst)
    (burst_we && !stop) |=> $stable(burst_q));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (release_req && grant) |=> release_req);

  a_r11_drop: assert property (@(posedge clk) disable iff (rst)
    !grant |=> !release_req);

  a_r6_rise_in_period: assert property (@(posedge clk) disable iff (rst)
    $rose(release_req) |-> $past(grant));
endmodule

bind bus_tenure_limiter blt_checker u_chk (
  .clk(clk), .rst(rst), .grant(grant), .stop(stop), .test_en(test_en),
  .burst_we(burst_we), .release_req(release_req), .burst_q(burst_q)
);

// File: tb/sim_bus_tenure_limiter.sv
`timescale 1ns/1ps
module sim_bus_tenure_limiter;
  localparam int D = 20;       // 200 MHz -> 20 clocks per 100 ns
  localparam int MAXE = 600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 0, xfer = 0, desc_xfer = 0, timer_en = 0, burst_dis = 0;
  logic stop = 0, test_en = 0, burst_we = 0, timer_we = 0;
  logic [7:0]  burst_wdata = '0;
  logic [15:0] timer_wdata = '0;
  logic release_req;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  bus_tenure_limiter #(.CLK_MHZ(200)) u0 (
    .clk(clk), .rst(rst), .grant(grant), .xfer(xfer), .desc_xfer(desc_xfer),
    .timer_en(timer_en), .burst_dis(burst_dis), .stop(stop), .test_en(test_en),
    .burst_we(burst_we), .burst_wdata(burst_wdata), .timer_we(timer_we),
    .timer_wdata(timer_wdata), .release_req(release_req)
  );

  // {req, burst, burst_dis, timer_en, timer, expected edge (0 = never)}
  localparam int NV = 9;
  localparam logic [45:0] VEC [NV] = '{
    {4'd2, 8'd16,  1'b0, 1'b0, 16'd0, 16'd16},  // R2
    {4'd2, 8'd5,   1'b0, 1'b0, 16'd0, 16'd5},   // R2
    {4'd3, 8'd0,   1'b0, 1'b0, 16'd0, 16'd1},   // R3
    {4'd2, 8'd255, 1'b0, 1'b0, 16'd0, 16'd255}, // R2
    {4'd7, 8'd40,  1'b0, 1'b1, 16'd1, 16'd20},  // R7: time first
    {4'd7, 8'd10,  1'b0, 1'b1, 16'd3, 16'd10},  // R7: count first
    {4'd6, 8'd8,   1'b1, 1'b1, 16'd2, 16'd40},  // R6 with R5
    {4'd8, 8'd8,   1'b1, 1'b1, 16'd0, 16'd1},   // R8
    {4'd5, 8'd3,   1'b1, 1'b0, 16'd0, 16'd0}    // R5: never
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_burst(input logic [7:0] v);
    @(negedge clk); burst_we = 1; burst_wdata = v;
    @(negedge clk); burst_we = 0;
  endtask

  task automatic wr_timer(input logic [15:0] v);
    @(negedge clk); timer_we = 1; timer_wdata = v;
    @(negedge clk); timer_we = 0;
  endtask

  // Grant with a data transfer every cycle; returns edge of release (0 = none).
  task automatic run_period(output int edge_at, input bit keep);
    int k;
    @(negedge clk); grant = 1; xfer = 1;
    k = 0; edge_at = 0;
    while (k < MAXE && edge_at == 0) begin
      @(negedge clk); k++;
      if (release_req) edge_at = k;
    end
    xfer = 0;
    if (!keep) begin grant = 0; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R11: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 release after reset", release_req, 0);
    run_period(got, 0);
    chk("R1 default burst 16", got, 16);

    for (int i = 0; i < NV; i++) begin
      logic [45:0] v;
      v = VEC[i];
      stop = 1; test_en = 0;
      wr_burst(v[41:34]);
      wr_timer(v[31:16]);
      stop = 0; burst_dis = v[33]; timer_en = v[32];
      run_period(got, 0);
      chk($sformatf("R%0d vector %0d", v[45:42], i), got, int'(v[15:0]));
    end
    burst_dis = 0; timer_en = 0;

    // R4: descriptor transfers not counted
    stop = 1; wr_burst(8'd4); stop = 0;
    @(negedge clk); grant = 1;
    for (int j = 0; j < 3; j++) begin
      xfer = 1; desc_xfer = 1; @(negedge clk);
      desc_xfer = 0; @(negedge clk);
    end
    xfer = 0;
    @(negedge clk);
    chk("R4 no release after 3 data + 3 desc", release_req, 0);
    xfer = 1; @(negedge clk); xfer = 0;
    chk("R4 release on 4th data", release_req, 1);
    // R11: holds while grant high, drops when grant low, restarts count
    repeat (5) @(negedge clk);
    chk("R11 held while granted", release_req, 1);
    grant = 0; @(negedge clk);
    chk("R11 drop after grant low", release_req, 0);
    run_period(got, 0);
    chk("R11 fresh period count", got, 4);

    // R9: test-mode decrement ignores data
    stop = 1; wr_burst(8'd6); test_en = 1; wr_burst(8'd99); test_en = 0; stop = 0;
    run_period(got, 0);
    chk("R9 decrement 6->5", got, 5);
    stop = 1; wr_burst(8'd0); test_en = 1; wr_burst(8'd7); test_en = 0; stop = 0;
    run_period(got, 0);
    chk("R9 decrement 0 wraps to 255", got, 255);

    // R10: write ignored when not stopped
    stop = 1; wr_burst(8'd7); stop = 0;
    wr_burst(8'd2);
    run_period(got, 0);
    chk("R10 locked write ignored", got, 7);

    // R6: grant without transfers still times out
    stop = 1; wr_burst(8'd1); wr_timer(16'd2); stop = 0; timer_en = 1;
    @(negedge clk); grant = 1;
    repeat (2*D - 1) @(negedge clk);
    chk("R6 low one edge before limit", release_req, 0);
    @(negedge clk);
    chk("R6 high at limit edge", release_req, 1);
    grant = 0; timer_en = 0; @(negedge clk);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule